// File: doc/BRIEF.md
# SDRAM Bank Activation Guard

This block sits in front of a DDR2 SDRAM command issuer and decides, every clock, whether the pending command may go out. The command can open a row in a bank (ACTIVATE), read or write in an open row, or close a bank (PRECHARGE). The block keeps an open or closed flag per bank. It also keeps the down-counters that enforce the activation timing rules. The command is granted in the same cycle it is presented. The grant updates state at the next rising edge. A refused command stalls and changes nothing.

The timing limits arrive as clock counts on configuration inputs. The shared package provides `ps_to_clk`, which turns a picosecond minimum and a picosecond clock period into the rounded-up clock count, so that software or parameters can derive those inputs. A `NUM_BANKS` parameter of 8 enables the four-activate rolling window. With 4 banks that window is not built.

Top module: `bank_act_guard`

## Requirements
- R1: After reset every bank reads closed on `bank_open`, and an ACTIVATE presented in the first cycle after reset is granted.
- R2: A READ (`req_cmd`=1) or WRITE (`req_cmd`=2) to a closed bank is refused with `grant`=0 and `stall`=1.
- R3: A READ or WRITE to a bank is granted no sooner than max(`cfg_trcd`,1) cycles after the ACTIVATE (`req_cmd`=0) of that bank. It is granted in exactly that cycle when it is polled every cycle.
- R4: An ACTIVATE to a bank that is already open is refused, whatever time has passed.
- R5: Two ACTIVATEs to the same bank are at least max(`cfg_trc`,1) cycles apart.
- R6: Two successive granted ACTIVATEs are at least max(`cfg_trrd`,1) cycles apart, including when they go to different banks.
- R7: With 8 banks, an ACTIVATE is granted only if the fourth-most-recent granted ACTIVATE lies at least max(`cfg_tfaw`,1) cycles in the past.
- R8: With 4 banks, `cfg_tfaw` has no effect on any grant.
- R9: A PRECHARGE (`req_cmd`=3) is always granted. It shows the bank closed from the next cycle on. It blocks a new ACTIVATE of that bank for max(`cfg_trp`,1) cycles.
- R10: A refused request changes neither `bank_open` nor any timing window.
- R11: With `req_valid` low, both `grant` and `stall` are low. With `req_valid` high, `stall` is the inverse of `grant`.
- R12: `ps_to_clk(t, tck)` returns the smallest n with n*tck >= t; for example 20000 ps at 3750 ps gives 6.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | A command is presented this cycle |
| req_cmd | input | 2 | 0 ACTIVATE, 1 READ, 2 WRITE, 3 PRECHARGE |
| req_bank | input | log2(NUM_BANKS) | Target bank |
| cfg_trcd | input | CNT_W | Activate-to-column delay, clocks |
| cfg_trc | input | CNT_W | Same-bank activate interval, clocks |
| cfg_trrd | input | CNT_W | Activate-to-activate spacing, clocks |
| cfg_tfaw | input | CNT_W | Four-activate window length, clocks |
| cfg_trp | input | CNT_W | Precharge-to-activate delay, clocks |
| grant | output | 1 | Presented command may issue this cycle |
| stall | output | 1 | Presented command is held back |
| bank_open | output | NUM_BANKS | Per-bank open-row flag |

## Verification
Each limit is swept over a range of clock counts, including 0 and 1, with a command polled every cycle. The cycle of the first grant then separates an off-by-one in the counter load from a missing limit. Same-bank reopen trials vary both the row interval and the precharge delay, so the bench can tell which of the two limits binds. Runs of five and six activations at the minimum spacing check the rolling window against its oldest entry. The same activation sequence is sent to a 4-bank and an 8-bank instance, and the two must give different grant cycles. Refused polls that come before a grant show that a refusal leaves all timing untouched.

// File: rtl/act_guard_pkg.sv
`timescale 1ns/1ps
package act_guard_pkg;

  typedef enum logic [1:0] {
    CMD_ACT = 2'd0,
    CMD_RD  = 2'd1,
    CMD_WR  = 2'd2,
    CMD_PRE = 2'd3
  } cmd_e;

  // Rounded-up conversion of a picosecond minimum into whole clocks.
  function automatic int unsigned ps_to_clk(input int unsigned t_ps,
                                            input int unsigned tck_ps);
    if (tck_ps == 0) return 0;
    return (t_ps + tck_ps - 1) / tck_ps;
  endfunction

endpackage

// File: rtl/agd_down_cnt.sv
`timescale 1ns/1ps
// Loadable down-counter: a load of span N reads zero again N cycles later.
module agd_down_cnt #(
  parameter int W = 6
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] span,
  output logic         expired
);

  logic [W-1:0] cnt;

  function automatic logic [W-1:0] span_to_load(input logic [W-1:0] s);
    return (s == '0) ? '0 : s - 1'b1;
  endfunction

  always_ff @(posedge clk) begin
    if (!rst_n)           cnt <= '0;
    else if (load)        cnt <= span_to_load(span);
    else if (cnt != '0)   cnt <= cnt - 1'b1;
  end

  assign expired = (cnt == '0);

endmodule

// File: rtl/agd_bank_slice.sv
`timescale 1ns/1ps
// Row state and per-bank timing for one bank.
module agd_bank_slice #(
  parameter int W = 6
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         act_hit,
  input  logic         pre_hit,
  input  logic [W-1:0] cfg_trcd,
  input  logic [W-1:0] cfg_trc,
  input  logic [W-1:0] cfg_trp,
  output logic         is_open,
  output logic         act_ready,
  output logic         col_ready
);

  logic rcd_done, rc_done, rp_done;

  always_ff @(posedge clk) begin
    if (!rst_n)       is_open <= 1'b0;
    else if (act_hit) is_open <= 1'b1;
    else if (pre_hit) is_open <= 1'b0;
  end

  agd_down_cnt #(.W(W)) u_rcd (
    .clk(clk), .rst_n(rst_n), .load(act_hit), .span(cfg_trcd), .expired(rcd_done));
  agd_down_cnt #(.W(W)) u_rc (
    .clk(clk), .rst_n(rst_n), .load(act_hit), .span(cfg_trc), .expired(rc_done));
  agd_down_cnt #(.W(W)) u_rp (
    .clk(clk), .rst_n(rst_n), .load(pre_hit), .span(cfg_trp), .expired(rp_done));

  assign act_ready = !is_open && rc_done && rp_done;
  assign col_ready = is_open && rcd_done;

endmodule

// File: rtl/agd_faw_window.sv
`timescale 1ns/1ps
// Rolling four-activate window: a ring of four counters, the pointer marks the oldest.
module agd_faw_window #(
  parameter int W      = 6,
  parameter bit ENABLE = 1'b1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         act_fire,
  input  logic [W-1:0] cfg_tfaw,
  output logic         faw_ok
);

  localparam int SLOTS = 4;

  generate
    if (ENABLE) begin : g_win
      logic [1:0]       oldest;
      logic [SLOTS-1:0] slot_done;

      always_ff @(posedge clk) begin
        if (!rst_n)        oldest <= '0;
        else if (act_fire) oldest <= oldest + 2'd1;
      end

      for (genvar s = 0; s < SLOTS; s++) begin : g_slot
        agd_down_cnt #(.W(W)) u_slot (
          .clk(clk), .rst_n(rst_n),
          .load(act_fire && (oldest == 2'(s))),
          .span(cfg_tfaw),
          .expired(slot_done[s]));
      end

      assign faw_ok = slot_done[oldest];
    end else begin : g_off
      logic unused_win;
      assign unused_win = ^{clk, rst_n, act_fire, cfg_tfaw};
      assign faw_ok = 1'b1;
    end
  endgenerate

endmodule

// File: rtl/bank_act_guard.sv
`timescale 1ns/1ps
module bank_act_guard
  import act_guard_pkg::*;
#(
  parameter int NUM_BANKS = 8,
  parameter int CNT_W     = 6,
  localparam int BANK_W   = $clog2(NUM_BANKS),
  localparam bit FAW_EN   = (NUM_BANKS == 8)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 req_valid,
  input  logic [1:0]           req_cmd,
  input  logic [BANK_W-1:0]    req_bank,
  input  logic [CNT_W-1:0]     cfg_trcd,
  input  logic [CNT_W-1:0]     cfg_trc,
  input  logic [CNT_W-1:0]     cfg_trrd,
  input  logic [CNT_W-1:0]     cfg_tfaw,
  input  logic [CNT_W-1:0]     cfg_trp,
  output logic                 grant,
  output logic                 stall,
  output logic [NUM_BANKS-1:0] bank_open
);

  cmd_e cmd;
  assign cmd = cmd_e'(req_cmd);

  // Named internal events, also observed by the checker.
  logic                 act_fire, rdwr_fire, pre_fire;
  logic                 rrd_done, faw_ok, act_ok, col_ok;
  logic [NUM_BANKS-1:0] act_ready, col_ready;

  assign act_ok = act_ready[req_bank] && rrd_done && faw_ok;
  assign col_ok = col_ready[req_bank];

  always_comb begin
    grant = 1'b0;
    if (req_valid) begin
      unique case (cmd)
        CMD_ACT:        grant = act_ok;
        CMD_RD, CMD_WR: grant = col_ok;
        CMD_PRE:        grant = 1'b1;
        default:        grant = 1'b0;
      endcase
    end
  end

  assign stall     = req_valid && !grant;
  assign act_fire  = grant && (cmd == CMD_ACT);
  assign rdwr_fire = grant && ((cmd == CMD_RD) || (cmd == CMD_WR));
  assign pre_fire  = grant && (cmd == CMD_PRE);

  generate
    for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
      agd_bank_slice #(.W(CNT_W)) u_slice (
        .clk(clk), .rst_n(rst_n),
        .act_hit(act_fire && (req_bank == BANK_W'(b))),
        .pre_hit(pre_fire && (req_bank == BANK_W'(b))),
        .cfg_trcd(cfg_trcd), .cfg_trc(cfg_trc), .cfg_trp(cfg_trp),
        .is_open(bank_open[b]),
        .act_ready(act_ready[b]),
        .col_ready(col_ready[b]));
    end
  endgenerate

  agd_down_cnt #(.W(CNT_W)) u_rrd (
    .clk(clk), .rst_n(rst_n), .load(act_fire), .span(cfg_trrd), .expired(rrd_done));

  agd_faw_window #(.W(CNT_W), .ENABLE(FAW_EN)) u_faw (
    .clk(clk), .rst_n(rst_n), .act_fire(act_fire), .cfg_tfaw(cfg_tfaw), .faw_ok(faw_ok));

endmodule

// File: rtl/bank_act_guard_chk.sv
`timescale 1ns/1ps
module bank_act_guard_chk #(
  parameter int NB = 8,
  parameter int CW = 6,
  localparam int BW = $clog2(NB)
) (
  input logic          clk,
  input logic          rst_n,
  input logic          req_valid,
  input logic [BW-1:0] req_bank,
  input logic [CW-1:0] cfg_trcd,
  input logic [CW-1:0] cfg_trrd,
  input logic          grant,
  input logic          stall,
  input logic [NB-1:0] bank_open,
  input logic          act_fire,
  input logic          rdwr_fire,
  input logic          pre_fire
);

  a_r2_col_needs_open: assert property (@(posedge clk) disable iff (!rst_n)
    rdwr_fire |-> bank_open[req_bank]);

  a_r4_act_needs_closed: assert property (@(posedge clk) disable iff (!rst_n)
    act_fire |-> !bank_open[req_bank]);

  a_r4_act_opens: assert property (@(posedge clk) disable iff (!rst_n)
    act_fire |=> bank_open[$past(req_bank)]);

  a_r3_rcd_gap: assert property (@(posedge clk) disable iff (!rst_n)
    (act_fire && cfg_trcd > 1) |=> !(rdwr_fire && req_bank == $past(req_bank)));

  a_r6_rrd_gap: assert property (@(posedge clk) disable iff (!rst_n)
    (act_fire && cfg_trrd > 1) |=> !act_fire);

  a_r9_pre_closes: assert property (@(posedge clk) disable iff (!rst_n)
    pre_fire |=> !bank_open[$past(req_bank)]);

  a_r10_deny_keeps: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !grant) |=> bank_open == $past(bank_open));

  a_r11_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |-> (!grant && !stall));

endmodule

bind bank_act_guard bank_act_guard_chk #(.NB(NUM_BANKS), .CW(CNT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_bank(req_bank),
  .cfg_trcd(cfg_trcd), .cfg_trrd(cfg_trrd), .grant(grant), .stall(stall),
  .bank_open(bank_open), .act_fire(act_fire), .rdwr_fire(rdwr_fire),
  .pre_fire(pre_fire));

// File: tb/bank_act_guard_tb.sv
`timescale 1ns/1ps
module bank_act_guard_tb;
  import act_guard_pkg::*;

  localparam int CW = 6;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          req_valid = 1'b0;
  logic [1:0]    req_cmd = 2'd0;
  logic [2:0]    req_bank = 3'd0;
  logic [CW-1:0] trcd = 6'd1, trc = 6'd1, trrd = 6'd1, tfaw = 6'd1, trp = 6'd1;
  logic          g8, s8, g4, s4;
  logic [7:0]    open8;
  logic [3:0]    open4;

  int cyc = 0;
  int n_chk = 0;
  int n_fail = 0;
  bit finished = 0;

  always #5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  bank_act_guard #(.NUM_BANKS(8), .CNT_W(CW)) u_dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_cmd(req_cmd),
    .req_bank(req_bank), .cfg_trcd(trcd), .cfg_trc(trc), .cfg_trrd(trrd),
    .cfg_tfaw(tfaw), .cfg_trp(trp), .grant(g8), .stall(s8), .bank_open(open8));

  bank_act_guard #(.NUM_BANKS(4), .CNT_W(CW)) u_dut4 (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_cmd(req_cmd),
    .req_bank(req_bank[1:0]), .cfg_trcd(trcd), .cfg_trc(trc), .cfg_trrd(trrd),
    .cfg_tfaw(tfaw), .cfg_trp(trp), .grant(g4), .stall(s4), .bank_open(open4));

  function automatic int mx(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

  task automatic check(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    req_valid = 1'b0;
    repeat (2) @(posedge clk);
    #1 rst_n = 1'b1;
  endtask

  // One cycle: present a command, sample the combinational grant, let the edge commit it.
  task automatic try(input logic [1:0] c, input logic [2:0] b, input bit sel,
                     output bit g, output bit s, output int t);
    @(negedge clk);
    req_valid = 1'b1;
    req_cmd   = c;
    req_bank  = b;
    #1;
    g = sel ? g4 : g8;
    s = sel ? s4 : s8;
    t = cyc;
    @(posedge clk);
    #1 req_valid = 1'b0;
  endtask

  task automatic poll(input logic [1:0] c, input logic [2:0] b, input bit sel,
                      output int at);
    bit g, s;
    int t;
    at = -1;
    for (int i = 0; i < 64; i++) begin
      try(c, b, sel, g, s, t);
      if (g) begin
        at = t;
        break;
      end
    end
  endtask

  task automatic set_cfg(input int a, input int b, input int c, input int d, input int e);
    trcd = CW'(a); trc = CW'(b); trrd = CW'(c); tfaw = CW'(d); trp = CW'(e);
  endtask

  initial begin
    bit g, s;
    int t0, t1, tp, ta[6];

    // R1: reset state and first activate
    set_cfg(3, 7, 2, 9, 3);
    do_reset();
    #1;
    check("R1 open8 after reset", open8, 0);
    check("R1 open4 after reset", open4, 0);
    try(2'd0, 3'd5, 0, g, s, t0);
    check("R1 first ACT granted", g, 1);
    #1;
    check("R1 bank5 open", open8[5], 1);

    // R11: idle request
    @(negedge clk);
    req_valid = 1'b0; req_cmd = 2'd0; req_bank = 3'd0;
    #1;
    check("R11 grant idle", g8, 0);
    check("R11 stall idle", s8, 0);

    // R2: column command to closed bank
    do_reset();
    try(2'd1, 3'd2, 0, g, s, t0);
    check("R2 RD closed grant", g, 0);
    check("R2 RD closed stall", s, 1);
    try(2'd2, 3'd6, 0, g, s, t0);
    check("R2 WR closed grant", g, 0);
    check("R11 stall is not grant", s, 1);

    // R3: activate-to-column sweep
    for (int d = 0; d <= 6; d++) begin
      set_cfg(d, 2, 1, 1, 1);
      do_reset();
      try(2'd0, 3'(d), 0, g, s, t0);
      poll((d % 2 == 0) ? 2'd1 : 2'd2, 3'(d), 0, t1);
      check($sformatf("R3 trcd=%0d gap", d), t1 - t0, mx(d, 1));
    end

    // R5 / R9: same-bank reopen against trc and trp
    for (int rc = 2; rc <= 9; rc++) begin
      for (int pi = 0; pi < 2; pi++) begin
        int rp;
        rp = (pi == 0) ? 1 : 4;
        set_cfg(1, rc, 1, 1, rp);
        do_reset();
        try(2'd0, 3'd3, 0, g, s, t0);
        try(2'd3, 3'd3, 0, g, s, tp);
        check("R9 PRE granted", g, 1);
        #1;
        check("R9 bank closed after PRE", open8[3], 0);
        poll(2'd0, 3'd3, 0, t1);
        check($sformatf("R5 trc=%0d trp=%0d reopen", rc, rp), t1, mx(t0 + rc, tp + rp));
      end
    end

    // R4: open bank cannot be re-activated
    set_cfg(1, 2, 1, 1, 1);
    do_reset();
    try(2'd0, 3'd1, 0, g, s, t0);
    repeat (4) @(posedge clk);
    try(2'd0, 3'd1, 0, g, s, t1);
    check("R4 ACT open bank refused", g, 0);
    check("R4 stall on open bank", s, 1);

    // R6: activate spacing sweep across banks
    for (int r = 0; r <= 5; r++) begin
      set_cfg(1, 1, r, 1, 1);
      do_reset();
      try(2'd0, 3'd0, 0, g, s, t0);
      poll(2'd0, 3'd3, 0, t1);
      check($sformatf("R6 trrd=%0d gap", r), t1 - t0, mx(r, 1));
    end

    // R10: refusals leave timing and state alone
    set_cfg(1, 1, 4, 1, 1);
    do_reset();
    try(2'd0, 3'd0, 0, g, s, t0);
    try(2'd0, 3'd0, 0, g, s, t1);
    check("R10 ACT open refused", g, 0);
    try(2'd1, 3'd6, 0, g, s, t1);
    #1;
    check("R10 open8 unchanged", open8, 8'h01);
    poll(2'd0, 3'd1, 0, t1);
    check("R10 trrd window not restarted", t1 - t0, 4);

    // R7: rolling four-activate window, 8 banks
    for (int w = 4; w <= 14; w++) begin
      set_cfg(1, 1, 2, w, 1);
      do_reset();
      for (int k = 0; k < 6; k++) poll(2'd0, 3'(k), 0, ta[k]);
      check($sformatf("R7 tfaw=%0d fifth", w), ta[4] - ta[0], mx(ta[3] + 2, ta[0] + w) - ta[0]);
      check($sformatf("R7 tfaw=%0d sixth", w), ta[5] - ta[0], mx(ta[4] + 2, ta[1] + w) - ta[0]);
    end

    // R8: same stimulus, window only on the 8-bank instance
    set_cfg(1, 1, 1, 20, 1);
    do_reset();
    for (int k = 0; k < 4; k++) poll(2'd0, 3'(k), 1, ta[k]);
    try(2'd3, 3'd0, 1, g, s, tp);
    poll(2'd0, 3'd0, 1, t1);
    check("R8 4-bank ignores tfaw", t1, tp + 1);
    poll(2'd0, 3'd0, 0, t1);
    check("R7 8-bank held by tfaw", t1 - ta[0], 20);

    // R12: rounded-up clock conversion
    foreach (ta[i]) ta[i] = 0;
    for (int ci = 0; ci < 4; ci++) begin
      for (int ti = 0; ti < 5; ti++) begin
        int unsigned tck, tns, n;
        tck = (ci == 0) ? 2500 : (ci == 1) ? 3000 : (ci == 2) ? 3750 : 5000;
        tns = (ti == 0) ? 0 : (ti == 1) ? 7500 : (ti == 2) ? 13125 : (ti == 3) ? 15000 : 20000;
        n = 0;
        while (n * tck < tns) n++;
        check($sformatf("R12 ps_to_clk(%0d,%0d)", tns, tck), int'(ps_to_clk(tns, tck)), int'(n));
      end
    end

    if (!finished) begin
      finished = 1;
      $display("  TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      n_chk++;
      n_fail++;
      $display("FAIL watchdog actual=%0d expected=0", cyc);
      $display("  TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
      $finish;
    end
  end

endmodule